// File: doc/BRIEF.md
# Run-Time Configurable Serial Character Transmitter

This block sends characters on a single asynchronous serial line. Software writes a character through a one-cycle data-write strobe. The character waits in a small queue until the shift engine can send it. The shape of every frame comes from one line-control byte, which is sampled when the frame begins. That byte sets the number of data bits (5 to 8), whether a parity bit is added and whether it is even or odd, whether one or two stop bits follow, and whether the queue works as a deep FIFO or as a single holding register.

Bit timing comes from an external baud generator as a one-cycle `bit_tick` pulse. Every serial bit lasts exactly one tick interval. Frames begin only on a tick. A character that is already queued when a frame ends is started on that same tick, so consecutive frames have no idle gap between them. Software polls `tx_full` before each write. A write made while `tx_full` is set is discarded.

Top module: `sertx_top`

## Requirements
- R1: After a synchronous active-low reset, `txd` is high, `tx_full` is low and the queue holds nothing.
- R2: A frame is a low start bit, then the data bits least-significant first, then the optional parity bit, then the high stop bit(s). Each bit lasts one `bit_tick` interval. A frame starts only on a tick. Queued characters follow each other with no idle bits between them, and the line rests high.
- R3: Line-control bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R4: Line-control bit 2 set adds a parity bit after the data. Bit 3 set selects even parity, where the count of ones over data plus parity is even. Bit 3 clear selects odd parity.
- R5: Line-control bit 4 set sends two stop bits. Bit 4 clear sends one stop bit.
- R6: Line-control bit 5 set enables the FIFO, which holds DEPTH characters (16 by default) in write order. `tx_full` is low while fewer than DEPTH are held and high once DEPTH are held.
- R7: With line-control bit 5 clear, the queue holds one character, and `tx_full` is high while that character waits.
- R8: A write presented while `tx_full` is high is dropped and leaves the queue unchanged.
- R9: The line-control byte is sampled when a frame starts. A change during a frame does not alter that frame and applies from the next frame on. Bits [7:6] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse from the baud generator, one per serial bit |
| line_ctl | input | 8 | Line-control byte (frame format and FIFO enable) |
| wr_en | input | 1 | Data-write strobe, one character per cycle |
| wr_data | input | 8 | Character to queue |
| txd | output | 1 | Serial output line, high when idle |
| tx_full | output | 1 | High while no further character can be accepted |

## Verification
The bench decodes the line at every tick and compares each frame against a model built from the requirements. It covers each data length, no parity, odd and even parity on data with odd and even counts of ones, and one and two stop bits. A parity sense swapped by mistake, a data order reversed, or a stop count off by one would each show up as a wrong bit in the decoded frame.

It fills the FIFO to exactly one less than its depth and then to its depth, and pushes one more write. A capacity that is off by one, or an overflow write that gets stored, shows up in the full flag or as an extra character on the line. The same check runs in single-register mode.

It also rewrites the line-control byte in the middle of a frame; a design that reads the byte live would corrupt that frame. Finally, it requires the 16 FIFO frames to be contiguous, which catches an idle bit inserted between characters.

// File: rtl/sertx_pkg.sv
// Shared definitions for the serial transmitter.
// Assumes: frame length never exceeds start + 8 data + parity + 2 stop bits.
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int MAX_FRAME = 1 + DATA_W + 1 + 2;
    localparam int LEN_W     = $clog2(MAX_FRAME + 1);

    // Line-control byte layout; the bit positions are decoded by the framer and queue.
    typedef struct packed {
        logic [1:0] spare;      // [7:6] no effect
        logic       fifo_on;    // [5]
        logic       two_stop;   // [4]
        logic       even_par;   // [3]
        logic       par_on;     // [2]
        logic [1:0] wlen;       // [1:0] 0..3 -> 5..8 data bits
    } line_ctl_t;

endpackage

// File: rtl/sertx_queue.sv
// Character queue. Works as a DEPTH-entry FIFO or as a one-entry holding
// register, chosen live by fifo_on. A push is accepted only while not full.
// Assumes: the consumer pops only when empty is low.
module sertx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_on,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [CW-1:0] cap;
    logic          accept, take;

    // Capacity follows the FIFO enable bit.
    always_comb begin
        cap    = fifo_on ? CW'(DEPTH) : CW'(1);
        full   = (count >= cap);
        empty  = (count == '0);
        accept = push && !full;
        take   = pop && !empty;
        head   = mem[rd_ptr];
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (take)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            count <= count + CW'(accept) - CW'(take);
        end
    end

    // R8
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R7
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && count != '0) |-> full);

    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CW'(DEPTH)));

endmodule

// File: rtl/sertx_framer.sv
// Frame builder and shifter. On a tick with a character available and the
// line free (or on the final bit of the current frame) it samples the
// line-control byte, builds the whole frame and shifts it out one bit per tick.
// Assumes: bit_tick is a single-cycle pulse.
module sertx_framer
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  line_ctl_t         lc,
    input  logic              have_data,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic              txd
);
    logic [MAX_FRAME-1:0] fv_next, shreg;
    logic [LEN_W-1:0]     len_next, len_r, idx;
    logic                 busy, last, start, pbit;
    int                   wl;

    // Build the next frame image and its length from the live line control.
    always_comb begin
        wl      = 5 + int'(lc.wlen);
        fv_next = '1;
        fv_next[0] = 1'b0;
        pbit    = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < wl) begin
                fv_next[i + 1] = head[i];
                pbit = pbit ^ head[i];
            end
        end
        if (!lc.even_par) pbit = ~pbit;
        for (int j = 0; j < MAX_FRAME; j++) begin
            if (lc.par_on && j == wl + 1) fv_next[j] = pbit;
        end
        len_next = LEN_W'(6) + LEN_W'(lc.wlen) + LEN_W'(lc.par_on)
                 + (lc.two_stop ? LEN_W'(2) : LEN_W'(1));
    end

    // Frame start decision: idle or finishing, on a tick, with data waiting.
    always_comb begin
        last  = busy && (idx == len_r - LEN_W'(1));
        start = bit_tick && have_data && (!busy || last);
        pop   = start;
        txd   = shreg[0];
    end

    // Shift engine, advancing once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            idx   <= '0;
            len_r <= '0;
        end else if (bit_tick) begin
            if (start) begin
                busy  <= 1'b1;
                shreg <= fv_next;
                idx   <= '0;
                len_r <= len_next;
            end else if (last) begin
                busy  <= 1'b0;
                shreg <= '1;
            end else if (busy) begin
                shreg <= {1'b1, shreg[MAX_FRAME-1:1]};
                idx   <= idx + LEN_W'(1);
            end
        end
    end

    // R2
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bit_tick));

    // R9
    lc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> $stable(len_r));

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx < len_r));

endmodule

// File: rtl/sertx_top.sv
// Serial transmitter top: character queue feeding the frame shifter.
// Assumes: bit_tick comes from an external baud generator in this clock domain.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic [7:0] line_ctl,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       tx_full
);
    line_ctl_t         lc;
    logic [DATA_W-1:0] head;
    logic              empty, pop;

    // Reinterpret the raw byte as its fields.
    always_comb lc = line_ctl_t'(line_ctl);

    sertx_queue #(.DEPTH(DEPTH), .W(DATA_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_on   (lc.fifo_on),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (tx_full)
    );

    sertx_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .lc        (lc),
        .have_data (!empty),
        .head      (head),
        .pop       (pop),
        .txd       (txd)
    );

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] line_ctl = 8'h03;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_full;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    logic lg [0:8191];
    int lg_n = 0;
    int rp = 0;

    // Stimulus table: {line control, data}.
    localparam logic [15:0] VEC [8] = '{
        16'h03A5, 16'h0E5B, 16'h14FF, 16'h1D2C,
        16'h0700, 16'h1F81, 16'h0013, 16'hF27F
    };

    sertx_top #(.DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_ctl(line_ctl),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .tx_full(tx_full)
    );

    always #5 clk = ~clk;

    // Baud tick: one pulse every 4 clocks while enabled.
    always @(posedge clk) begin
        if (!rst_n || !tick_en) begin
            tcnt     <= 0;
            bit_tick <= 1'b0;
        end else begin
            tcnt     <= (tcnt == 3) ? 0 : tcnt + 1;
            bit_tick <= (tcnt == 3);
        end
    end

    // Line monitor: record the bit on the line at the end of each bit period.
    always @(negedge clk) begin
        if (rst_n && bit_tick && lg_n < 8192) begin
            lg[lg_n] = txd;
            lg_n = lg_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // Expected frame from the requirements.
    task automatic model(input logic [7:0] lc, input logic [7:0] d,
                         output logic [11:0] bits, output int n);
        int wl;
        int ones;
        wl = 5 + int'(lc[1:0]);
        ones = 0;
        bits = '1;
        bits[0] = 1'b0;
        n = 1;
        for (int i = 0; i < wl; i++) begin
            bits[n] = d[i];
            ones += int'(d[i]);
            n++;
        end
        if (lc[2]) begin
            bits[n] = lc[3] ? ((ones % 2) == 1) : ((ones % 2) == 0);
            n++;
        end
        n += lc[4] ? 2 : 1;
    endtask

    task automatic expect_frame(input logic [7:0] lc, input logic [7:0] d,
                                input bit strict, input string req);
        logic [11:0] eb;
        logic [11:0] gb;
        int n;
        model(lc, d, eb, n);
        if (!strict) while (rp < lg_n && lg[rp] == 1'b1) rp++;
        gb = '1;
        for (int i = 0; i < n; i++) gb[i] = (rp + i < lg_n) ? lg[rp + i] : 1'bx;
        check(gb === eb, req, "frame bits", int'(gb), int'(eb));
        rp += n;
    endtask

    task automatic expect_idle(input string req);
        int bad;
        bad = 0;
        for (int i = rp; i < lg_n; i++) if (lg[i] !== 1'b1) bad++;
        check(bad == 0, req, "line idle after frames (non-high bits)", bad, 0);
        rp = lg_n;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_wait(3);
        // R1: reset state
        check(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
        rst_n = 1'b1;
        idle_wait(1);
        check(txd === 1'b1 && tx_full === 1'b0, "R1", "txd/full after reset",
              int'({txd, tx_full}), 2);
        tick_en = 1'b1;
        idle_wait(20);
        rp = lg_n;

        // R2 R3 R4 R5 R9: table of formats, one frame each
        for (int v = 0; v < 8; v++) begin
            line_ctl = VEC[v][15:8];
            rp = lg_n;
            do_write(VEC[v][7:0]);
            idle_wait(70);
            expect_frame(VEC[v][15:8], VEC[v][7:0], 1'b0, "R2/R3/R4/R5");
            expect_idle("R2");
        end

        // R7 R8: single holding register with ticks stopped
        tick_en  = 1'b0;
        line_ctl = 8'h03;
        idle_wait(4);
        do_write(8'h3C);
        check(tx_full === 1'b1, "R7", "full with one pending, FIFO off", int'(tx_full), 1);
        do_write(8'hC3);
        check(tx_full === 1'b1, "R8", "full after dropped write", int'(tx_full), 1);
        rp = lg_n;
        tick_en = 1'b1;
        idle_wait(120);
        expect_frame(8'h03, 8'h3C, 1'b0, "R7");
        expect_idle("R8");
        check(tx_full === 1'b0, "R7", "full clears after send", int'(tx_full), 0);

        // R6 R8 R2: FIFO fill, overflow, back-to-back drain
        tick_en  = 1'b0;
        line_ctl = 8'h23;
        idle_wait(4);
        for (int k = 0; k < 15; k++) do_write(8'(k * 17 + 3));
        check(tx_full === 1'b0, "R6", "not full at depth-1", int'(tx_full), 0);
        do_write(8'(15 * 17 + 3));
        check(tx_full === 1'b1, "R6", "full at depth", int'(tx_full), 1);
        do_write(8'hEE);
        check(tx_full === 1'b1, "R8", "full after overflow write", int'(tx_full), 1);
        rp = lg_n;
        tick_en = 1'b1;
        idle_wait(800);
        for (int k = 0; k < 16; k++)
            expect_frame(8'h23, 8'(k * 17 + 3), (k != 0), "R6/R2");
        expect_idle("R8");
        check(tx_full === 1'b0, "R6", "full clears after drain", int'(tx_full), 0);

        // R9: line control changed mid-frame
        line_ctl = 8'h03;
        rp = lg_n;
        do_write(8'h96);
        idle_wait(24);
        line_ctl = 8'h14;
        idle_wait(60);
        expect_frame(8'h03, 8'h96, 1'b0, "R9");
        do_write(8'h0B);
        idle_wait(70);
        expect_frame(8'h14, 8'h0B, 1'b0, "R9");
        expect_idle("R9");

        // R1: reset mid-frame returns the line to idle
        line_ctl = 8'h03;
        do_write(8'h00);
        idle_wait(12);
        rst_n = 1'b0;
        idle_wait(1);
        rst_n = 1'b1;
        idle_wait(1);
        check(txd === 1'b1 && tx_full === 1'b0, "R1", "idle after mid-frame reset",
              int'({txd, tx_full}), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule